// File: doc/BRIEF.md
# Fully-associative translation cache with least-recently-used replacement

This block holds recently completed virtual-to-physical page translations so that a 20-bit virtual page number can be resolved without a walk through memory. Each of its 64 slots can hold any translation, tagged by the whole virtual page number. A lookup is answered in the same cycle. On a hit the block returns the 20-bit physical page number and the control bits stored with it. On a miss it raises a miss flag, so the requester can start a page walk.

When the walker returns, it presents a fill. If a valid slot already holds the same virtual page, the fill overwrites that slot in place. If not, the fill goes to the lowest-numbered empty slot, or, when every slot is full, to the slot that was used least recently. With 4 KiB pages, 64 slots cover a 256 KiB working set with no misses. A flush empties the whole structure in one cycle, for example when the address space changes.

Top module: `tlb_lru`

## Requirements
- R1: After reset no slot is valid, so every lookup misses.
- R2: When `lk_valid` is high and a valid slot holds `lk_vpn`, `lk_hit` is 1 in the same cycle and `lk_ppn` and `lk_ctl` carry that slot's contents. Bit 0 of the control field is the cacheable flag. The block stores and returns every control bit unchanged.
- R3: `lk_miss` is 1 exactly when `lk_valid` is high and no valid slot matches. While `lk_valid` is low, `lk_hit` and `lk_miss` are both 0. On a miss, `lk_ppn` and `lk_ctl` are 0.
- R4: While a slot is still empty, a fill with a new tag never removes a valid translation. Sixty-four fills with distinct tags after reset all remain resident.
- R5: When all slots are valid, a fill with a new tag replaces the least recently used translation and leaves every other translation in place.
- R6: A lookup hit makes its slot the most recently used.
- R7: A fill makes the slot it writes the most recently used.
- R8: A fill whose tag matches a valid slot rewrites that slot. Later lookups return the new data, and no other translation is lost.
- R9: A flush makes every lookup miss from the next cycle on. A flush takes priority over a fill in the same cycle, so that fill is dropped.
- R10: When a fill and a lookup hit occur in the same cycle, the lookup returns the contents from before the fill, and only the filled slot is promoted to most recently used.
- R11: A fill is visible to lookups from the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup is requested this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | The lookup matched a valid slot |
| lk_miss | output | 1 | The lookup matched no valid slot |
| lk_ppn | output | 20 | Physical page number of the matching slot, 0 on a miss |
| lk_ctl | output | 4 | Control bits of the matching slot (bit 0 is cacheable), 0 on a miss |
| fl_valid | input | 1 | Write a translation this cycle |
| fl_vpn | input | 20 | Virtual page number of the fill |
| fl_ppn | input | 20 | Physical page number of the fill |
| fl_ctl | input | 4 | Control bits of the fill |
| flush | input | 1 | Invalidate every slot |

## Verification
Lookup results are combinational, so each hit, miss, page number and control value is due in the same cycle that the lookup is driven. The bench drives inputs just after the falling edge and samples the outputs 1 ns later, before the next rising edge. Fills, flushes and recency updates take effect at the next rising edge. The bench's model applies them only after that edge, so the first lookup that can see them is the one in the following cycle.

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int CTL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [CTL_W-1:0] lk_ctl,
  input  logic             fl_valid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PPN_W-1:0] fl_ppn,
  input  logic [CTL_W-1:0] fl_ctl,
  input  logic             flush
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, lk_match, fl_match, mru_vec, lru_vec;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [CTL_W-1:0]   ctl_q [ENTRIES];
  logic [IDX_W-1:0]   age_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, same_idx, free_idx, lru_idx, victim, touch_idx, touch_age;
  logic             any_lk, any_same, all_full, fill_we, touch_en;

  assign any_lk   = |lk_match;
  assign any_same = |fl_match;
  assign all_full = &valid_q;
  assign fill_we  = fl_valid && !flush;
  assign lk_hit   = lk_valid && any_lk;
  assign lk_miss  = lk_valid && !any_lk;

  always_comb begin
    lk_idx = '0;
    same_idx = '0;
    lru_idx = '0;
    free_idx = '0;
    lk_ppn = '0;
    lk_ctl = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = IDX_W'(i);
      if (fl_match[i]) same_idx = IDX_W'(i);
      if (lru_vec[i])  lru_idx = IDX_W'(i);
      if (lk_valid && lk_match[i]) begin
        lk_ppn = lk_ppn | ppn_q[i];
        lk_ctl = lk_ctl | ctl_q[i];
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDX_W'(i);
  end

  assign victim    = any_same ? same_idx : (!all_full ? free_idx : lru_idx);
  assign touch_en  = !flush && (fl_valid || lk_hit);
  assign touch_idx = fl_valid ? victim : lk_idx;
  assign touch_age = age_q[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    assign fl_match[g] = valid_q[g] && (tag_q[g] == fl_vpn);
    assign mru_vec[g]  = (age_q[g] == '0);
    assign lru_vec[g]  = (age_q[g] == OLDEST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        age_q[g]   <= IDX_W'(g);
      end else if (flush) begin
        valid_q[g] <= 1'b0;
        age_q[g]   <= IDX_W'(g);
      end else begin
        if (fill_we && victim == IDX_W'(g)) valid_q[g] <= 1'b1;
        if (touch_en) begin
          if (touch_idx == IDX_W'(g))    age_q[g] <= '0;
          else if (age_q[g] < touch_age) age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (fill_we && victim == IDX_W'(g)) begin
        tag_q[g] <= fl_vpn;
        ppn_q[g] <= fl_ppn;
        ctl_q[g] <= fl_ctl;
      end
    end
  end

  AST_LOOKUP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R9
  AST_MRU_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mru_vec)); // R6
  AST_LRU_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lru_vec)); // R5
  AST_FILL_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> mru_vec[$past(victim)]); // R7
  AST_FILL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !any_same && !all_full) |=>
      ($countones(valid_q) == $countones($past(valid_q)) + 1)); // R4
endmodule

// File: tb/tlb_lru_tb_top.sv
`timescale 1ns/1ps
module tlb_lru_tb_top;
  localparam int N = 64;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fl_valid = 0, flush = 0;
  logic [19:0] lk_vpn = '0, fl_vpn = '0, fl_ppn = '0;
  logic [3:0] fl_ctl = '0;
  logic lk_hit, lk_miss;
  logic [19:0] lk_ppn;
  logic [3:0] lk_ctl;
  int tests = 0, fails = 0;
  bit done = 0;

  bit m_valid [N];
  int m_tag [N], m_ppn [N], m_ctl [N];
  int order [$];

  always #2 clk = ~clk;

  tlb_lru dut_i (.clk, .rst_n, .lk_valid, .lk_vpn, .lk_hit, .lk_miss, .lk_ppn, .lk_ctl,
                 .fl_valid, .fl_vpn, .fl_ppn, .fl_ctl, .flush);

  function automatic int find(int vpn);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void touch(int idx);
    for (int i = 0; i < order.size(); i++)
      if (order[i] == idx) begin order.delete(i); break; end
    order.push_front(idx);
  endfunction

  task automatic step(string req, bit lv, int lvpn, bit fv, int fvpn, int fppn, int fctl, bit fsh);
    int m, v;
    logic [45:0] exp_v, act_v;
    @(negedge clk);
    lk_valid = lv; lk_vpn = 20'(lvpn);
    fl_valid = fv; fl_vpn = 20'(fvpn); fl_ppn = 20'(fppn); fl_ctl = 4'(fctl);
    flush = fsh;
    #1;
    m = lv ? find(lvpn) : -1;
    exp_v = {lv && m >= 0, lv && m < 0,
             (m >= 0) ? 20'(m_ppn[m]) : 20'd0, (m >= 0) ? 4'(m_ctl[m]) : 4'd0};
    act_v = {lk_hit, lk_miss, lk_ppn, lk_ctl};
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: vpn=%h actual=%h expected=%h", req, lvpn, act_v, exp_v);
    end
    @(posedge clk);
    if (fsh) begin
      for (int i = 0; i < N; i++) m_valid[i] = 0;
    end else if (fv) begin
      v = find(fvpn);
      if (v < 0) for (int i = 0; i < N; i++) if (!m_valid[i]) begin v = i; break; end
      if (v < 0) v = order[$];
      m_valid[v] = 1; m_tag[v] = fvpn; m_ppn[v] = fppn; m_ctl[v] = fctl;
      touch(v);
    end else if (m >= 0) touch(m);
  endtask

  function automatic int tg(int i); return 32'h1000 + i * 7; endfunction

  initial begin
    for (int i = 0; i < N; i++) order.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step("R1", 1, tg(0), 0, 0, 0, 0, 0);
    step("R3", 0, tg(0), 0, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) begin
      step("R11", 1, tg(i), 1, tg(i), i * 3 + 5, i % 16, 0);
      step("R2", 1, tg(i), 0, 0, 0, 0, 0);
    end
    for (int i = 0; i < N; i++) step("R4", 1, tg(i), 0, 0, 0, 0, 0);
    step("R3", 1, 32'hABCDE, 0, 0, 0, 0, 0);
    step("R3", 0, tg(5), 0, 0, 0, 0, 0);
    step("R6", 1, tg(0), 0, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 32'h77777, 32'h12345, 1, 0);
    step("R6", 1, tg(0), 0, 0, 0, 0, 0);
    step("R5", 1, tg(1), 0, 0, 0, 0, 0);
    step("R5", 1, 32'h77777, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 1, tg(2), 32'h0BEEF, 9, 0);
    step("R8", 1, tg(2), 0, 0, 0, 0, 0);
    for (int i = 3; i < N; i++) step("R8", 1, tg(i), 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 32'h55555, 32'h00042, 2, 0);
    step("R7", 1, tg(3), 0, 0, 0, 0, 0);
    step("R10", 1, tg(4), 1, 32'h66666, 32'h00077, 3, 0);
    step("R10", 1, tg(4), 0, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 32'h66667, 32'h00078, 3, 0);
    step("R10", 1, tg(4), 0, 0, 0, 0, 0);
    step("R9", 1, tg(6), 1, 32'h99999, 1, 1, 1);
    step("R9", 1, tg(6), 0, 0, 0, 0, 0);
    step("R9", 1, 32'h99999, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      step(r < 45 ? "R2" : "R5", r < 70, $urandom_range(0, 79), r >= 45, $urandom_range(0, 79),
           $urandom, $urandom_range(0, 15), r == 99);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule